// File: doc/BRIEF.md
# Three-Port Parallel I/O Adaptor (Simple I/O Mode)

This block gives a microprocessor-style bus access to three 8-bit parallel ports, called A, B and C, plus a control register. The bus has an active-low chip select, separate active-low read and write strobes, a 2-bit address, and separate 8-bit data-in and data-out buses. Every port has its own input bus, its own output bus, and an active-low direction enable that an external tri-state driver uses. Port A and port B each have one enable. Port C has one enable per pin.

The ports fall into two groups. The first group is port A with the upper nibble of port C. The second group is port B with the lower nibble of port C. The four sections (A, B, C-high, C-low) each take their own direction from a mode-set word written to the control address. A second kind of control write sets or clears a single port C bit without touching the other bits. The block is fully synchronous to the rising clock edge. A write is taken once per falling edge of the write access, so holding the strobe low for several clocks changes the registers only once.

Top module: `par_io_ctrl`

## Requirements
- R1: While reset is high and afterwards until the first write, the control word reads 0x9B, all output buses are 0x00 and every direction enable is 1 (input).
- R2: Address 2'b00 selects port A, 2'b01 selects port B, 2'b10 selects port C and 2'b11 selects the control word, for both reads and writes.
- R3: A write happens only with cs_n=0, wr_n=0 and rd_n=1. A read drives dout only with cs_n=0, rd_n=0 and wr_n=1. In every other case dout is 0x00 and no register changes.
- R4: A write access that stays asserted over several clocks updates the registers once, with the data present at the first rising edge of the access.
- R5: In a mode-set word (bit 7 = 1), a 1 means input. Bit 4 drives a_dir_n. Bit 3 drives c_dir_n[7:4]. Bit 1 drives b_dir_n. Bit 0 drives c_dir_n[3:0].
- R6: A mode-set write clears the A, B and C output latches to 0x00.
- R7: A control write with bit 7 = 0 sets port C bit din[3:1] to din[0]. The other port C bits and the control word stay unchanged.
- R8: A read of port A or port B returns the output latch when the port is an output. When the port is an input, it returns the value its input bus had at the previous rising edge.
- R9: A read of port C chooses latch or sampled input separately for each nibble, following that nibble's direction bit.
- R10: A write to port A, B or C loads the output latch, and the new value appears on the matching output bus after the write edge.
- R11: A read of address 2'b11 returns the last mode-set word written, or 0x9B after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0x00 when no read is active |
| a_in | input | 8 | Port A input bus |
| b_in | input | 8 | Port B input bus |
| c_in | input | 8 | Port C input bus |
| a_out | output | 8 | Port A output latch |
| b_out | output | 8 | Port B output latch |
| c_out | output | 8 | Port C output latch |
| a_dir_n | output | 1 | Port A direction enable, 0 = driving |
| b_dir_n | output | 1 | Port B direction enable, 0 = driving |
| c_dir_n | output | 8 | Port C direction enable per pin, 0 = driving |

## Verification
A wrong control register shows up on the direction enables right after the edge that loads it. It also shows up on the very next read of any port, because the read path then picks the latch where it should pick the sampled input, or the other way round. A wrong latch bit appears on the port's output bus after one edge, and in the read data whenever that port is an output. The bench sweeps all sixteen direction combinations and every port C bit set/reset command, so a slip in the decode or in the nibble split is seen within a few cycles of the write that exposes it.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } pio_sel_e;

    // control word bit positions
    localparam int CB_MODESET = 7;
    localparam int CB_A_IN    = 4;
    localparam int CB_CHI_IN  = 3;
    localparam int CB_B_IN    = 1;
    localparam int CB_CLO_IN  = 0;

    localparam logic [7:0] CTRL_RST = 8'h9B;
endpackage

// File: rtl/pio_bus_qual.sv
module pio_bus_qual (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_pulse,
    output logic rd_act
);
    typedef struct packed {
        logic wr_seen;
    } qual_t;

    qual_t st_d, st_q;
    logic  wr_act;

    always_comb begin
        wr_act   = !cs_n && !wr_n && rd_n;
        rd_act   = !cs_n && !rd_n && wr_n;
        wr_pulse = wr_act && !st_q.wr_seen;
        st_d         = st_q;
        st_d.wr_seen = wr_act;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R4: one update per write access
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_pulse,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] ctrl,
    output logic [DW-1:0] a_lat,
    output logic [DW-1:0] b_lat,
    output logic [DW-1:0] c_lat
);
    localparam int SELW = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] c;
    } regs_t;

    regs_t         r_d, r_q;
    logic [SELW-1:0] bit_sel;

    always_comb begin
        r_d     = r_q;
        bit_sel = din[SELW:1];
        if (wr_pulse) begin
            unique case (pio_sel_e'(addr))
                SEL_A: r_d.a = din;
                SEL_B: r_d.b = din;
                SEL_C: r_d.c = din;
                SEL_CTRL: begin
                    if (din[CB_MODESET]) begin
                        r_d.ctrl = din;
                        r_d.a    = '0;
                        r_d.b    = '0;
                        r_d.c    = '0;
                    end else begin
                        r_d.c[bit_sel] = din[0];
                    end
                end
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.ctrl <= CTRL_RST;
            r_q.a    <= '0;
            r_q.b    <= '0;
            r_q.c    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl  = r_q.ctrl;
    assign a_lat = r_q.a;
    assign b_lat = r_q.b;
    assign c_lat = r_q.c;

    // R3: no access, no change of the control word
    a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_pulse |=> $stable(r_q.ctrl));
    // R6: mode-set clears every latch
    a_r6_clear_latches: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && addr == 2'b11 && din[CB_MODESET]) |=>
            (r_q.a == '0 && r_q.b == '0 && r_q.c == '0));
    // R7: bit set/reset leaves the control word alone
    a_r7_bsr_ctrl_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && addr == 2'b11 && !din[CB_MODESET]) |=> $stable(r_q.ctrl));
endmodule

// File: rtl/pio_rd_path.sv
module pio_rd_path
    import pio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_act,
    input  logic [1:0]    addr,
    input  logic          a_is_in,
    input  logic          b_is_in,
    input  logic          chi_is_in,
    input  logic          clo_is_in,
    input  logic [DW-1:0] ctrl,
    input  logic [DW-1:0] a_lat,
    input  logic [DW-1:0] b_lat,
    input  logic [DW-1:0] c_lat,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic [DW-1:0] c_in,
    output logic [DW-1:0] dout
);
    localparam int HALF = DW / 2;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] c;
    } smp_t;

    smp_t          s_d, s_q;
    logic [DW-1:0] c_view;
    logic [DW-1:0] sel_val;

    always_comb begin
        s_d.a = a_in;
        s_d.b = b_in;
        s_d.c = c_in;

        c_view[DW-1:HALF] = chi_is_in ? s_q.c[DW-1:HALF] : c_lat[DW-1:HALF];
        c_view[HALF-1:0]  = clo_is_in ? s_q.c[HALF-1:0]  : c_lat[HALF-1:0];

        unique case (pio_sel_e'(addr))
            SEL_A:    sel_val = a_is_in ? s_q.a : a_lat;
            SEL_B:    sel_val = b_is_in ? s_q.b : b_lat;
            SEL_C:    sel_val = c_view;
            SEL_CTRL: sel_val = ctrl;
            default:  sel_val = '0;
        endcase
        dout = rd_act ? sel_val : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/par_io_ctrl.sv
module par_io_ctrl
    import pio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic [DW-1:0] c_in,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] b_out,
    output logic [DW-1:0] c_out,
    output logic          a_dir_n,
    output logic          b_dir_n,
    output logic [DW-1:0] c_dir_n
);
    localparam int HALF = DW / 2;

    logic          wr_pulse;
    logic          rd_act;
    logic [DW-1:0] ctrl;

    pio_bus_qual u_qual (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .wr_pulse (wr_pulse),
        .rd_act   (rd_act)
    );

    pio_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_pulse (wr_pulse),
        .addr     (addr),
        .din      (din),
        .ctrl     (ctrl),
        .a_lat    (a_out),
        .b_lat    (b_out),
        .c_lat    (c_out)
    );

    pio_rd_path #(.DW(DW)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_act    (rd_act),
        .addr      (addr),
        .a_is_in   (ctrl[CB_A_IN]),
        .b_is_in   (ctrl[CB_B_IN]),
        .chi_is_in (ctrl[CB_CHI_IN]),
        .clo_is_in (ctrl[CB_CLO_IN]),
        .ctrl      (ctrl),
        .a_lat     (a_out),
        .b_lat     (b_out),
        .c_lat     (c_out),
        .a_in      (a_in),
        .b_in      (b_in),
        .c_in      (c_in),
        .dout      (dout)
    );

    assign a_dir_n = ctrl[CB_A_IN];
    assign b_dir_n = ctrl[CB_B_IN];
    assign c_dir_n = {{HALF{ctrl[CB_CHI_IN]}}, {HALF{ctrl[CB_CLO_IN]}}};

    // R3: read data stays quiet unless a read is qualified
    a_r3_dout_quiet: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n || !wr_n) |-> (dout == '0));
    // R5: each port C nibble moves as one group
    a_r5_c_nibbles: assert property (@(posedge clk) disable iff (rst)
        ($countones(c_dir_n[DW-1:HALF]) == 0 || $countones(c_dir_n[DW-1:HALF]) == HALF) &&
        ($countones(c_dir_n[HALF-1:0]) == 0 || $countones(c_dir_n[HALF-1:0]) == HALF));
endmodule

// File: tb/par_io_ctrl_tb.sv
module par_io_ctrl_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic [7:0] a_in = 8'h00, b_in = 8'h00, c_in = 8'h00;
    logic [7:0] a_out, b_out, c_out;
    logic       a_dir_n, b_dir_n;
    logic [7:0] c_dir_n;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // bench model
    logic [7:0] m_ctrl = 8'h9B, m_a = 8'h00, m_b = 8'h00, m_c = 8'h00;

    always #(CLK_P/2) clk = ~clk;

    par_io_ctrl u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout),
        .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .a_out(a_out), .b_out(b_out), .c_out(c_out),
        .a_dir_n(a_dir_n), .b_dir_n(b_dir_n), .c_dir_n(c_dir_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] ad);
        logic [7:0] v;
        case (ad)
            2'b00: v = m_ctrl[4] ? a_in : m_a;
            2'b01: v = m_ctrl[1] ? b_in : m_b;
            2'b10: begin
                v[7:4] = m_ctrl[3] ? c_in[7:4] : m_c[7:4];
                v[3:0] = m_ctrl[0] ? c_in[3:0] : m_c[3:0];
            end
            default: v = m_ctrl;
        endcase
        return v;
    endfunction

    task automatic bus_write(input logic [1:0] ad, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; addr = ad; din = d;
        @(posedge clk);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        case (ad)
            2'b00: m_a = d;
            2'b01: m_b = d;
            2'b10: m_c = d;
            default: begin
                if (d[7]) begin
                    m_ctrl = d; m_a = 8'h00; m_b = 8'h00; m_c = 8'h00;
                end else begin
                    m_c[d[3:1]] = d[0];
                end
            end
        endcase
    endtask

    task automatic bus_read(input logic [1:0] ad, input string req);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = ad;
        #(CLK_P/4);
        check(req, {8'h00, dout}, {8'h00, exp_read(ad)});
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic check_dirs(input string req);
        check(req, {6'd0, a_dir_n, b_dir_n, c_dir_n},
              {6'd0, m_ctrl[4], m_ctrl[1], {4{m_ctrl[3]}}, {4{m_ctrl[0]}}});
    endtask

    task automatic check_outs(input string req);
        check(req, {8'h00, a_out}, {8'h00, m_a});
        check(req, {8'h00, b_out}, {8'h00, m_b});
        check(req, {8'h00, c_out}, {8'h00, m_c});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, checked during reset and after it
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_dirs("R1 dirs in reset");
        check_outs("R1 outputs in reset");
        rst = 1'b0;
        @(negedge clk);
        check_dirs("R1 dirs after reset");
        bus_read(2'b11, "R1/R11 control reset value");

        // R2/R5/R6/R8/R9/R10: sweep all sixteen direction sets
        for (int i = 0; i < 16; i++) begin
            logic [7:0] mw;
            mw = {1'b1, 2'b00, i[3], i[2], 1'b0, i[1], i[0]};
            bus_write(2'b00, 8'hFF);
            bus_write(2'b11, mw);
            @(negedge clk);
            check_dirs("R5 direction enables");
            check_outs("R6 latches cleared by mode-set");
            bus_write(2'b00, 8'(i * 37 + 5));
            bus_write(2'b01, 8'(i * 59 + 17));
            bus_write(2'b10, 8'(i * 23 + 200));
            a_in = 8'(i * 11 + 90);
            b_in = 8'(i * 13 + 7);
            c_in = 8'(i * 71 + 33);
            @(posedge clk);
            @(negedge clk);
            check_outs("R10 latches on output buses");
            bus_read(2'b00, "R2/R8 port A read");
            bus_read(2'b01, "R2/R8 port B read");
            bus_read(2'b10, "R2/R9 port C nibble read");
            bus_read(2'b11, "R2/R11 control readback");
        end

        // R7: set then clear each port C bit
        bus_write(2'b11, 8'h80);
        for (int k = 0; k < 8; k++) begin
            bus_write(2'b11, {4'h0, 3'(k), 1'b1});
            @(negedge clk);
            check("R7 bit set", {8'h00, c_out}, {8'h00, m_c});
        end
        for (int k = 0; k < 8; k++) begin
            bus_write(2'b11, {4'h0, 3'(k), 1'b0});
            @(negedge clk);
            check("R7 bit clear", {8'h00, c_out}, {8'h00, m_c});
        end
        bus_read(2'b11, "R7 control unchanged by bit commands");

        // R4: held write strobe, data changes mid-access
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'b00; din = 8'h5A;
        @(posedge clk);
        @(negedge clk);
        din = 8'hA5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        m_a = 8'h5A;
        check("R4 one update per held write", {8'h00, a_out}, 16'h005A);

        // R3: disqualified writes and reads
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'b00; din = 8'h33;
        @(posedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        check("R3 no write with cs_n high", {8'h00, a_out}, 16'h005A);
        cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; din = 8'h44;
        #(CLK_P/4);
        check("R3 dout quiet with both strobes low", {8'h00, dout}, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        check("R3 no write with both strobes low", {8'h00, a_out}, 16'h005A);
        rd_n = 1'b0;
        #(CLK_P/4);
        check("R3 dout quiet with cs_n high", {8'h00, dout}, 16'h0000);
        rd_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule